// File: doc/BRIEF.md
# Oversampled Serial Receiver with Tagged Character Queue

This block is the receive half of an asynchronous serial port. It samples the incoming line once per oversampling tick, supplied from outside at 16 or 8 ticks per bit. It treats a falling edge on an idle line as a candidate start bit and confirms it at mid-bit. It then collects 5 to 8 data bits with the least significant bit first, optionally checks a parity bit, and checks the stop bit. Each finished character goes into a small queue. Every queue entry carries four status bits beside the eight data bits.

The receiver is a state machine with six states. WAIT_HIGH holds until the line reads high. IDLE waits for the line to go low. START confirms the start bit at mid-bit. DATA collects the character bits. PARITY captures the parity bit. STOP samples the stop bit and issues the write to the queue. The transitions are as follows:
- WAIT_HIGH moves to IDLE on a tick where the line is high.
- IDLE moves to START on a tick where the line is low.
- START returns to IDLE if the line is high at mid-bit. Otherwise it moves to DATA at the end of the bit.
- DATA moves to PARITY or to STOP after the last data bit, depending on whether parity is enabled.
- PARITY moves to STOP at the end of its bit.
- STOP moves to IDLE at mid-bit if the stop bit is high, and to WAIT_HIGH if it is low.

The host reads the head entry and pops it with a one-cycle read strobe. The line input passes through a synchronizer whose depth is a parameter. The configuration inputs must stay stable while a character is being received.

Top module: `uart_rx_status_fifo`

## Requirements
- R1: After reset the queue is empty (`rx_empty`=1, `rx_full`=0) and the receiver waits for the line to be high before it accepts a start bit.
- R2: A low line is accepted as a start bit only if it is still low at sample 8 of 16 (mode 16x) or at sample 4 of 8 (mode 8x), where the first tick that sees the low line is sample 1. Otherwise no entry is written.
- R3: The character length is 5 + `char_len` bits (`char_len` 0 to 3). Bits are received least significant first, each sampled at mid-bit, and stored right-aligned in entry bits [7:0] with the unused upper bits zero.
- R4: `os_8x`=0 selects 16 ticks per bit and `os_8x`=1 selects 8 ticks per bit. Both the start check and data sampling use the mid-bit tick of the chosen mode.
- R5: With `par_en`=1, a parity bit follows the data. The parity is even when `par_odd`=0 and odd when `par_odd`=1. A mismatch sets entry bit [9].
- R6: A stop bit sampled low sets entry bit [8] (framing error). The character is still stored.
- R7: A character whose data bits are all zero and whose stop bit is low sets entry bit [10] (break) together with bit [8]. After any low stop bit, no new start is accepted until the line has been high for a tick.
- R8: A character that completes while the queue is full and is not being popped is discarded. It sets bit [11] (overrun) on the most recently stored entry.
- R9: Entries leave in arrival order. `rd_data` shows the head entry. `rd_en` pops it when the queue is not empty. `rx_full` is 1 when `FIFO_DEPTH` entries are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_in | input | 1 | Serial line, idle high |
| os_tick | input | 1 | One-cycle oversampling tick |
| os_8x | input | 1 | 0: 16 ticks per bit, 1: 8 ticks per bit |
| char_len | input | 2 | Character length code, length = 5 + value |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| rd_en | input | 1 | Pop the head entry |
| rd_data | output | 12 | Head entry: [11] overrun, [10] break, [9] parity error, [8] framing error, [7:0] data |
| rx_empty | output | 1 | Queue holds no entry |
| rx_full | output | 1 | Queue holds FIFO_DEPTH entries |

## Verification
A character's entry becomes visible two clock cycles after the tick at which the stop bit is sampled. That tick falls at mid-stop-bit, so the entry appears well before the frame's full stop bit ends. The bench therefore finishes each frame (the whole stop bit, a high recovery bit after a low stop, and two idle ticks) before it samples `rd_data` and the flags on a falling clock edge. A pop takes effect at the next rising edge after `rd_en` is raised, and the new head is read on the following falling edge. Each frame starts on a tick boundary, so the start check and the mid-bit samples land on the ticks the requirements count.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    localparam int DATA_W  = 8;
    localparam int FLAG_W  = 3;              // flags produced by the framer
    localparam int ENTRY_W = DATA_W + FLAG_W + 1;
    localparam int FL_FRAME  = 0;
    localparam int FL_PARITY = 1;
    localparam int FL_BREAK  = 2;

    typedef enum logic [2:0] {
        ST_WAIT_HIGH,
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx,
    input  logic              os_8x,
    input  logic [1:0]        char_len,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              push,
    output logic [DATA_W-1:0] push_data,
    output logic [FLAG_W-1:0] push_flags
);
    rx_state_t         state, state_n;
    logic [3:0]        sub;        // ticks already spent in the current bit
    logic [2:0]        bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              par_bit;

    logic [3:0] mid_cnt, end_cnt;
    logic [2:0] last_bit;
    logic       at_mid, at_end;

    assign mid_cnt  = os_8x ? 4'd3 : 4'd7;
    assign end_cnt  = os_8x ? 4'd7 : 4'd15;
    assign last_bit = {1'b1, char_len};      // 4 + char_len
    assign at_mid   = (sub == mid_cnt);
    assign at_end   = (sub == end_cnt);

    // next-state logic
    always_comb begin
        state_n = state;
        if (tick) begin
            unique case (state)
                ST_WAIT_HIGH: if (rx) state_n = ST_IDLE;
                ST_IDLE:      if (!rx) state_n = ST_START;
                ST_START: begin
                    if (at_mid && rx)  state_n = ST_IDLE;
                    else if (at_end)   state_n = ST_DATA;
                end
                ST_DATA: begin
                    if (at_end && bit_idx == last_bit)
                        state_n = par_en ? ST_PARITY : ST_STOP;
                end
                ST_PARITY:    if (at_end) state_n = ST_STOP;
                ST_STOP:      if (at_mid) state_n = rx ? ST_IDLE : ST_WAIT_HIGH;
                default:      state_n = ST_WAIT_HIGH;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_WAIT_HIGH;
        else        state <= state_n;
    end

    // counters, capture and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub        <= 4'd1;
            bit_idx    <= '0;
            shreg      <= '0;
            par_bit    <= 1'b0;
            push       <= 1'b0;
            push_data  <= '0;
            push_flags <= '0;
        end else begin
            push <= 1'b0;
            if (tick) begin
                unique case (state)
                    ST_WAIT_HIGH: sub <= 4'd1;
                    ST_IDLE: begin
                        sub     <= 4'd1;
                        bit_idx <= '0;
                        shreg   <= '0;
                    end
                    ST_START: sub <= at_end ? 4'd0 : sub + 4'd1;
                    ST_DATA: begin
                        sub <= at_end ? 4'd0 : sub + 4'd1;
                        if (at_mid) shreg[bit_idx] <= rx;
                        if (at_end) bit_idx <= bit_idx + 3'd1;
                    end
                    ST_PARITY: begin
                        sub <= at_end ? 4'd0 : sub + 4'd1;
                        if (at_mid) par_bit <= rx;
                    end
                    ST_STOP: begin
                        sub <= sub + 4'd1;
                        if (at_mid) begin
                            push                  <= 1'b1;
                            push_data             <= shreg;
                            push_flags[FL_FRAME]  <= !rx;
                            push_flags[FL_PARITY] <= par_en & (^shreg ^ par_bit ^ par_odd);
                            push_flags[FL_BREAK]  <= !rx && (shreg == '0);
                        end
                    end
                    default: sub <= 4'd1;
                endcase
            end
        end
    end

    p_push_from_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> ($past(state) == ST_STOP && $past(tick)));
    p_break_sets_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && push_flags[FL_BREAK]) |-> push_flags[FL_FRAME]);
    p_hold_low_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_HIGH && !rx) |=> state == ST_WAIT_HIGH);
    p_sub_in_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sub <= end_cnt);
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [FLAG_W-1:0]  wr_flags,
    input  logic               rd,
    output logic [ENTRY_W-1:0] head,
    output logic               empty,
    output logic               full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] dmem [DEPTH];
    logic [FLAG_W-1:0] fmem [DEPTH];
    logic [DEPTH-1:0]  ovr;
    logic [AW-1:0]     wr_ptr, rd_ptr, newest;
    logic [CW-1:0]     count;
    logic              do_pop, do_push, lost;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_pop  = rd && !empty;
    assign do_push = wr && (!full || do_pop);
    assign lost    = wr && full && !do_pop;
    assign newest  = wr_ptr - 1'b1;
    assign head    = {ovr[rd_ptr], fmem[rd_ptr], dmem[rd_ptr]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovr    <= '0;
        end else begin
            if (do_push) begin
                dmem[wr_ptr] <= wr_data;
                fmem[wr_ptr] <= wr_flags;
                ovr[wr_ptr]  <= 1'b0;
                wr_ptr       <= wr_ptr + 1'b1;
            end
            if (lost) ovr[newest] <= 1'b1;
            if (do_pop) rd_ptr <= rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr && !rd) |=> (full && count == $past(count)));
    p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
    p_pop_shrinks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !empty && !wr) |=> count == $past(count) - 1'b1);
    p_push_from_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && wr) |=> !empty);
endmodule

// File: rtl/uart_rx_status_fifo.sv
module uart_rx_status_fifo
    import uart_rx_pkg::*;
#(
    parameter int FIFO_DEPTH  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_in,
    input  logic               os_tick,
    input  logic               os_8x,
    input  logic [1:0]         char_len,
    input  logic               par_en,
    input  logic               par_odd,
    input  logic               rd_en,
    output logic [ENTRY_W-1:0] rd_data,
    output logic               rx_empty,
    output logic               rx_full
);
    logic              rx_s;
    logic              push;
    logic [DATA_W-1:0] push_data;
    logic [FLAG_W-1:0] push_flags;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(rx_in), .q(rx_s)
    );

    uart_rx_framer u_framer (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx(rx_s),
        .os_8x(os_8x), .char_len(char_len), .par_en(par_en), .par_odd(par_odd),
        .push(push), .push_data(push_data), .push_flags(push_flags)
    );

    uart_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr(push), .wr_data(push_data),
        .wr_flags(push_flags), .rd(rd_en), .head(rd_data),
        .empty(rx_empty), .full(rx_full)
    );

    p_reset_empty_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (rx_empty && !rx_full));
endmodule

// File: tb/test_uart_rx_status_fifo.sv
`timescale 1ns/1ps
module test_uart_rx_status_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_in = 1'b1;
    logic        os_tick = 1'b0;
    logic        os_8x = 1'b0;
    logic [1:0]  char_len = 2'd3;
    logic        par_en = 1'b0;
    logic        par_odd = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] rd_data;
    logic        rx_empty, rx_full;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;   // 250 MHz

    uart_rx_status_fifo i_uart_rx_status_fifo (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .os_tick(os_tick),
        .os_8x(os_8x), .char_len(char_len), .par_en(par_en), .par_odd(par_odd),
        .rd_en(rd_en), .rd_data(rd_data), .rx_empty(rx_empty), .rx_full(rx_full)
    );

    // vector: [18] 8x, [17:16] len code, [15] par_en, [14] par_odd,
    //         [13] parity bit sent, [12] stop bit, [11:8] status, [7:0] data
    localparam logic [18:0] VEC [9] = '{
        {1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 4'h0, 8'hA5},
        {1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 4'h0, 8'h3C},
        {1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 4'h0, 8'h15},
        {1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 4'h0, 8'h55},
        {1'b0, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 4'h2, 8'h01},
        {1'b1, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 4'h0, 8'h2A},
        {1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 4'h1, 8'h81},
        {1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 4'h5, 8'h00},
        {1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 4'h0, 8'h7F}
    };

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            os_tick = 1'b1;
            @(negedge clk);
            os_tick = 1'b0;
        end
    end

    function automatic void report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endfunction

    task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %03h expected %03h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic v, input int n);
        rx_in = v;
        repeat (n) @(posedge os_tick);
    endtask

    task automatic send_frame(input int nbits, input logic [7:0] d, input logic pen,
                              input logic pbit, input logic stop, input int n);
        @(posedge os_tick);
        send_bit(1'b0, n);
        for (int i = 0; i < nbits; i++) send_bit(d[i], n);
        if (pen) send_bit(pbit, n);
        send_bit(stop, n);
        if (!stop) send_bit(1'b1, n);
        send_bit(1'b1, 2);
        @(negedge clk);
    endtask

    task automatic pop();
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        check("R1 reset flags", {10'd0, rx_empty, rx_full}, 12'b10);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 flags after release", {10'd0, rx_empty, rx_full}, 12'b10);

        // table of frames
        for (int v = 0; v < 9; v++) begin
            int n;
            os_8x    = VEC[v][18];
            char_len = VEC[v][17:16];
            par_en   = VEC[v][15];
            par_odd  = VEC[v][14];
            n = VEC[v][18] ? 8 : 16;
            send_frame(5 + int'(VEC[v][17:16]), VEC[v][7:0], VEC[v][15],
                       VEC[v][13], VEC[v][12], n);
            // R3 R4 R5 R6 R7: entry contents per vector
            check($sformatf("R3/R4/R5/R6/R7 vector %0d entry", v), rd_data, VEC[v][11:0]);
            pop();
            @(negedge clk);
            check($sformatf("R9 vector %0d empty after pop", v), {11'd0, rx_empty}, 12'd1);
        end

        // R2: short low pulses rejected in each mode
        os_8x = 1'b0; char_len = 2'd3; par_en = 1'b0;
        @(posedge os_tick);
        send_bit(1'b0, 7);
        send_bit(1'b1, 40);
        @(negedge clk);
        check("R2 16x pulse of 7 ticks ignored", {11'd0, rx_empty}, 12'd1);
        os_8x = 1'b1;
        @(posedge os_tick);
        send_bit(1'b0, 3);
        send_bit(1'b1, 24);
        @(negedge clk);
        check("R2 8x pulse of 3 ticks ignored", {11'd0, rx_empty}, 12'd1);

        // R7: break with long low line, then recovery
        os_8x = 1'b0;
        @(posedge os_tick);
        send_bit(1'b0, 16 * 12);
        send_bit(1'b1, 20);
        @(negedge clk);
        check("R7 single break entry", rd_data, 12'h500);
        pop();
        @(negedge clk);
        check("R7 no entry during held low line", {11'd0, rx_empty}, 12'd1);
        send_frame(8, 8'h5A, 1'b0, 1'b0, 1'b1, 16);
        check("R7 reception resumes after break", rd_data, 12'h05A);
        pop();

        // R8: overrun with a depth-4 queue
        for (int k = 1; k <= 5; k++)
            send_frame(8, 8'(k * 17), 1'b0, 1'b0, 1'b1, 16);
        check("R9 full after four entries", {11'd0, rx_full}, 12'd1);
        for (int k = 1; k <= 4; k++) begin
            logic [11:0] exp;
            exp = (k == 4) ? {4'h8, 8'(k * 17)} : {4'h0, 8'(k * 17)};
            check($sformatf("R8/R9 entry %0d order and overrun tag", k), rd_data, exp);
            pop();
            @(negedge clk);
        end
        check("R8 fifth character discarded", {11'd0, rx_empty}, 12'd1);

        report();
        $finish;
    end
endmodule